// File: doc/BRIEF.md
# Frequent Value Bus Encoder

This block sits on the transmit side of a 32-bit off-chip data bus. It cuts down the number of wires that toggle when the same words are sent again and again. It keeps a table of 32 recently seen full-width words. When a new word equals one of them exactly, the block does not send the word. It sends a one-hot code instead, and the single set bit names the matching table slot. It also raises one side-band flag, so the receiver can tell that the bus carries a code and not raw data.

When a word is not in the table, it goes out unchanged with the flag low, and it is written into the table. Slots fill in order from slot 0. Once the table is full, each new word takes the next slot in round-robin order, so the oldest word is overwritten. The receiver keeps a copy of the table that follows the same rules, and it rebuilds each word from the code it receives. Results are registered, so the bus value for a word appears one clock after that word is accepted. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `freqval_bus_encoder`

## Requirements
- R1: While reset is held and after reset is released, `bus_o` is 0 and `enc_o` is 0 until the first accepted word, and every table slot is empty.
- R2: An accepted word that is not in the table is driven on `bus_o` unchanged with `enc_o` = 0, and it is stored in the table.
- R3: An accepted word that equals a stored entry drives `bus_o` = 1 << s, where s is the index of the matching slot, with `enc_o` = 1.
- R4: A hit requires all 32 bits to be equal. A word that differs from every stored entry in at least one bit is treated as a miss.
- R5: Stored words take slots 0, 1, 2, … in order and wrap from the last slot back to 0. A miss on a full table overwrites the slot that was written longest ago.
- R6: While `valid_i` is low, `bus_o`, `enc_o` and the table contents keep their values, whatever `data_i` carries.
- R7: The bus value and flag for a word accepted at clock edge n appear at the outputs after edge n, with one register stage of latency. A repeat of that word accepted at edge n+1 is already a hit.
- R8: A word that is already stored is never written again, so a hit does not move the replacement position.
- R9: Whenever `enc_o` is 1, `bus_o` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_i | input | 1 | High when `data_i` holds a word to send |
| data_i | input | 32 | Word to send |
| bus_o | output | 32 | Registered bus value: the raw word, or a one-hot slot code |
| enc_o | output | 1 | High when `bus_o` carries a slot code |

## Verification
Two functions can act in the same cycle: the table write caused by a miss, and the lookup of the next word, which reads the table just after that write. The bench provokes this by sending a new word and then the same word on the next cycle. It also sends a word just after its slot was overwritten by a replacement. A correct design must report a hit in the first case and a miss in the second. The bench judges every cycle against a behavioural copy of the receiver's table that is updated with the same slot order.

// File: rtl/freqval_pkg.sv
package freqval_pkg;
  // Default geometry: bus width and number of table slots
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_ENTRIES = 32;

  // Meaning of the word currently on the bus
  typedef enum logic {
    BUS_RAW  = 1'b0,
    BUS_CODE = 1'b1
  } bus_kind_e;
endpackage

// File: rtl/freqval_rst_sync.sv
module freqval_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/freqval_table.sv
module freqval_table #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  lookup_i,
  input  logic               wr_en_i,
  output logic [ENTRIES-1:0] hit_vec_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [DATA_W-1:0]  entry_q [ENTRIES];
  logic [ENTRIES-1:0] entry_vld_q;
  logic [ENTRIES-1:0] entry_vld_d;
  logic [ENTRIES-1:0] slot_wr;
  logic [IDX_W-1:0]   wr_ptr_q;
  logic [IDX_W-1:0]   wr_ptr_d;

  // Replacement position: advance on each write, wrapping at the last slot
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    if (wr_en_i) begin
      wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_q <= '0;
    else         wr_ptr_q <= wr_ptr_d;
  end

  always_comb begin
    entry_vld_d = entry_vld_q | slot_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) entry_vld_q <= '0;
    else         entry_vld_q <= entry_vld_d;
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_slot
      assign slot_wr[g]   = wr_en_i && (wr_ptr_q == IDX_W'(g));
      assign hit_vec_o[g] = entry_vld_q[g] && (entry_q[g] == lookup_i);

      // Data storage has no reset: the valid bit qualifies it
      always_ff @(posedge clk_i) begin
        if (slot_wr[g]) entry_q[g] <= lookup_i;
      end
    end
  endgenerate

  // R8: no word is ever stored twice, so at most one slot matches
  p_single_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o));

  // R5: each write moves the replacement position one slot on, with wrap
  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (wr_ptr_q == (($past(wr_ptr_q) == LAST_IDX) ? '0
                               : $past(wr_ptr_q) + IDX_W'(1))));

  // R8: without a write the replacement position stays put
  p_ptr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_q));

  // R2: a written slot holds the written word and becomes valid
  p_stored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (entry_vld_q[$past(wr_ptr_q)] &&
                 entry_q[$past(wr_ptr_q)] == $past(lookup_i)));
endmodule

// File: rtl/freqval_pick.sv
module freqval_pick #(
  parameter int unsigned ENTRIES = 32
) (
  input  logic [ENTRIES-1:0] hit_vec_i,
  output logic [ENTRIES-1:0] code_o,
  output logic               any_o
);
  // Keep the lowest set bit, so the code stays one-hot in every case
  always_comb begin
    code_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) code_o = ENTRIES'(1) << i;
    end
  end

  assign any_o = |hit_vec_i;
endmodule

// File: rtl/freqval_bus_encoder.sv
module freqval_bus_encoder
  import freqval_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              enc_o
);
  logic               rst_n_sync;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] code;
  logic               any_hit;
  logic               tbl_wr;
  logic [DATA_W-1:0]  bus_d, bus_q;
  bus_kind_e          kind_d, kind_q;

  freqval_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  freqval_table #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .lookup_i  (data_i),
    .wr_en_i   (tbl_wr),
    .hit_vec_o (hit_vec)
  );

  freqval_pick #(.ENTRIES(ENTRIES)) u_pick (
    .hit_vec_i (hit_vec),
    .code_o    (code),
    .any_o     (any_hit)
  );

  assign tbl_wr = valid_i && !any_hit;

  always_comb begin
    bus_d  = bus_q;
    kind_d = kind_q;
    if (valid_i) begin
      if (any_hit) begin
        bus_d  = DATA_W'(code);
        kind_d = BUS_CODE;
      end else begin
        bus_d  = data_i;
        kind_d = BUS_RAW;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      bus_q  <= '0;
      kind_q <= BUS_RAW;
    end else if (valid_i) begin
      bus_q  <= bus_d;
      kind_q <= kind_d;
    end
  end

  assign bus_o = bus_q;
  assign enc_o = (kind_q == BUS_CODE);

  // R6: idle input leaves the outputs unchanged
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !valid_i |=> ($stable(bus_o) && $stable(enc_o)));

  // R9: a coded bus value has exactly one bit set
  p_code_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    enc_o |-> $onehot(bus_o));

  // R7: a missed word appears raw one cycle later
  p_raw_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (valid_i && !(|hit_vec)) |=> (!enc_o && bus_o == $past(data_i)));

  // R3: a table match yields a coded cycle next
  p_hit_coded_r3: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (valid_i && (|hit_vec)) |=> enc_o);
endmodule

// File: tb/freqval_bus_encoder_tb.sv
module freqval_bus_encoder_tb;
  localparam int W = 32;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] bus;
  logic         enc;

  int checks = 0;
  int fails  = 0;

  // Receiver-side model of the table
  logic [W-1:0] m_tbl [N];
  logic         m_vld [N];
  int           m_ptr = 0;
  logic [W-1:0] exp_bus = '0;
  logic         exp_enc = 1'b0;

  always #4 clk = ~clk;

  freqval_bus_encoder #(.DATA_W(W), .ENTRIES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data),
    .bus_o(bus), .enc_o(enc)
  );

  task automatic check(input string tag, input logic [W-1:0] ab, input logic ae,
                       input logic [W-1:0] eb, input logic ee);
    checks++;
    if (ab !== eb || ae !== ee) begin
      fails++;
      $display("FAIL %s: bus=%h enc=%b expected bus=%h enc=%b", tag, ab, ae, eb, ee);
    end
  endtask

  // Apply one cycle of input; the result is checked after the next edge (R7)
  task automatic step(input logic v, input logic [W-1:0] d, input string tag);
    int hit_idx;
    hit_idx = -1;
    valid = v;
    data  = d;
    if (v) begin
      for (int i = 0; i < N; i++)
        if (m_vld[i] && m_tbl[i] == d && hit_idx < 0) hit_idx = i;
      if (hit_idx >= 0) begin
        exp_bus = W'(1) << hit_idx;
        exp_enc = 1'b1;
      end else begin
        exp_bus = d;
        exp_enc = 1'b0;
        m_tbl[m_ptr] = d;
        m_vld[m_ptr] = 1'b1;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, bus, enc, exp_bus, exp_enc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] lfsr;
    logic [W-1:0] pick;
    for (int i = 0; i < N; i++) begin m_tbl[i] = '0; m_vld[i] = 1'b0; end

    // R1: reset state, while held and after release
    repeat (3) @(negedge clk);
    check("R1 held", bus, enc, '0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 released", bus, enc, '0, 1'b0);
    // R1: table empty, so a word equal to the reset bus value is a miss
    step(1'b1, 32'h0000_0000, "R1 empty table");

    // R2/R5: fill the table with distinct words
    for (int i = 1; i < N; i++) step(1'b1, 32'hA500_0000 ^ (i * 32'h0101_0101), "R2 fill");
    // R3/R9: replay in reverse, each must hit its slot
    for (int i = N - 1; i >= 1; i--) step(1'b1, 32'hA500_0000 ^ (i * 32'h0101_0101), "R3 replay");
    step(1'b1, 32'h0, "R3 slot0");

    // R6: idle cycles with changing data hold the outputs and the table
    for (int i = 0; i < 8; i++) step(1'b0, 32'hDEAD_0000 + i, "R6 idle");
    step(1'b1, 32'hA500_0000 ^ (5 * 32'h0101_0101), "R6 table intact");

    // R4: single-bit differences from slot 5 are misses (and evict, R5)
    for (int b = 0; b < W; b++)
      step(1'b1, (32'hA500_0000 ^ (5 * 32'h0101_0101)) ^ (W'(1) << b), "R4 one-bit diff");
    // R5: the originals were overwritten in round-robin order
    for (int i = 1; i < 4; i++) step(1'b1, 32'hA500_0000 ^ (i * 32'h0101_0101), "R5 evicted");

    // R7/R8: new word then immediate repeat, then a miss lands in the next slot
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 32'h1234_0000 + i, "R7 new");
      step(1'b1, 32'h1234_0000 + i, "R7 back-to-back hit");
      step(1'b1, 32'h1234_0000 + i, "R8 repeat no write");
    end

    // Near-exhaustive mix from a small pool, with idle gaps
    lfsr = 32'h1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pick = 32'h7700_0000 | W'(lfsr % 45);
      step(lfsr[7:5] != 3'b000, pick, "R3 mixed stream");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule